// File: doc/BRIEF.md
# Serial Controller Configuration Space Responder

This block holds the 256-byte configuration register space of a simple serial controller function. A host-side access engine presents an address, four byte enables, write data and a write strobe. The block returns read data combinationally from a shadow byte array. Most fields in that array are fixed identification constants. Only a few fields can be written, and each follows its own rule.

The function exposes one or two 8-byte I/O windows through its base address registers. A parameter selects between a single-port and a dual-port build. The BARs support the usual sizing handshake: software writes all ones and reads back the size mask, and the I/O type bits are never disturbed. The interrupt-line byte is the only other field that software can change. A synchronous reset restores every field.

Top module: `serial_cfg_space`

## Requirements
- R1: The dword at offset 0x04 reads 0x02000001 after reset. That value is a command word of 0x0001 in bytes 0x04..0x05 and a status word of 0x0200 in bytes 0x06..0x07. Writes to that dword leave it unchanged.
- R2: The dword at offset 0x08 reads 0x07000210: revision 0x10 at byte 0x08, interface code 0x02 at 0x09, subclass 0x00 at 0x0A and base class 0x07 at 0x0B.
- R3: BAR0 (dword 0x10) resets to 0x00000001. In the dual-port build, BAR1 (dword 0x14) also resets to 0x00000001.
- R4: A write with all four byte enables set and data 0xFFFFFFFF to a present BAR makes that BAR read 0xFFFFFFF9. This value is the size mask of an 8-byte window with the I/O type bits 01 kept.
- R5: Any other write to a present BAR stores the written bits 31..2, while bits 1..0 stay 01. For example, writing 0x0000C0F2 makes the BAR read 0x0000C0F1.
- R6: A write with only some byte enables set changes only the enabled bytes of a BAR and keeps bits 1..0 at 01. A partial write of all-ones data stores the data and does not perform sizing.
- R7: In the single-port build, BAR1 always reads 0 and writes to it are discarded.
- R8: Dwords 0x18, 0x1C and 0x20 read 0, including after any write to them.
- R9: Byte 0x3C (interrupt line) is writable through byte enable 0 and resets to 0. Byte 0x3D (interrupt pin) always reads 0x01. Byte 0x34 (capability pointer) reads 0.
- R10: The dword at 0x2C reads the same value as the identification dword at 0x00, which is the ID_WORD parameter.
- R11: Read lane i returns the byte at offset addr+i when byteEn[i] is set. A lane whose byte enable is clear reads 0, and a lane whose offset lies past 0xFF reads 0, so reads may be unaligned.
- R12: A write targets the aligned dword addr[7:2], and lane i maps to byte 4*addr[7:2]+i. Writes to unlisted offsets (for example 0x40) have no effect, and nothing changes while wrEn is low.
- R13: Asserting rst for one clock returns BAR0, BAR1 and the interrupt line to their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset of the access |
| byteEn | input | 4 | Lane enables for read and write |
| wrData | input | 32 | Write data, lane i in bits 8i+7..8i |
| wrEn | input | 1 | Write strobe, applied at the clock edge |
| rdData | output | 32 | Combinational read data |

## Verification
The bench distinguishes a full all-ones BAR write from a partial all-ones write. A design that sized on the data alone would return 0xFFFFFFF9 where 0x00FFFFFD is expected. It writes BAR values with odd low bits, such as 0x...F2 and an 0xFF byte. A design that stored those bits verbatim would lose the I/O type code. Both builds run side by side on a shared bus: a single-port design that kept BAR1 would read back a value at 0x14 instead of 0. Unaligned writes and reads check that write lanes land in the aligned dword while read lanes slide with the address. A design that mixed these up would return shifted bytes.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  // Fixed field values of the function
  localparam logic [15:0] CMD_RESET   = 16'h0001;
  localparam logic [15:0] STAT_RESET  = 16'h0200;
  localparam logic [7:0]  REV_ID      = 8'h10;
  localparam logic [7:0]  PROG_IF     = 8'h02;
  localparam logic [7:0]  SUB_CLASS   = 8'h00;
  localparam logic [7:0]  BASE_CLASS  = 8'h07;
  localparam logic [7:0]  INT_PIN     = 8'h01;
  localparam logic [7:0]  CAP_PTR     = 8'h00;
  localparam logic [1:0]  IO_TYPE     = 2'b01;

  // Dword indices (offset / 4)
  localparam logic [5:0] DW_BAR0     = 6'h04;
  localparam logic [5:0] DW_BAR1     = 6'h05;
  localparam logic [5:0] DW_INTR     = 6'h0F;

  localparam int MAX_BARS = 2;

  // Control-to-datapath strobes
  typedef struct packed {
    logic [MAX_BARS-1:0] barHit;
    logic                barSize;
    logic                lineWe;
    logic [3:0]          laneMask;
  } cfgStrobes_t;

endpackage

// File: rtl/serial_cfg_wr_ctrl.sv
module serial_cfg_wr_ctrl
  import serial_cfg_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic [5:0]  dwIdx,
  input  logic [3:0]  byteEn,
  input  logic [31:0] wrData,
  input  logic        wrEn,
  output cfgStrobes_t strobes
);

  localparam bit HAS_BAR1 = (NUM_PORTS == 2);

  always_comb begin
    strobes.barHit[0] = wrEn && (dwIdx == DW_BAR0);
    strobes.barHit[1] = wrEn && HAS_BAR1 && (dwIdx == DW_BAR1);
    strobes.barSize   = (byteEn == 4'hF) && (wrData == 32'hFFFF_FFFF);
    strobes.lineWe    = wrEn && (dwIdx == DW_INTR) && byteEn[0];
    strobes.laneMask  = byteEn;
  end

endmodule

// File: rtl/serial_cfg_dp.sv
module serial_cfg_dp
  import serial_cfg_pkg::*;
#(
  parameter int          NUM_PORTS  = 2,
  parameter int          BAR_WINDOW = 8,
  parameter logic [31:0] ID_WORD    = 32'hC0DE_5A01
) (
  input  logic        clk,
  input  logic        rst,
  input  cfgStrobes_t strobes,
  input  logic [31:0] wrData,
  input  logic [7:0]  addr,
  input  logic [3:0]  byteEn,
  output logic [31:0] rdData
);

  localparam logic [31:0] SIZE_MASK  = ~(32'(BAR_WINDOW)) + 32'd1;
  localparam logic [31:0] BAR_RESET  = {30'd0, IO_TYPE};
  localparam logic [31:0] SIZED_VAL  = SIZE_MASK | BAR_RESET;

  logic [31:0] barVal [MAX_BARS];
  logic [7:0]  intLine;

  for (genvar b = 0; b < MAX_BARS; b++) begin : g_bar
    if (b < NUM_PORTS) begin : g_present
      logic [31:0] merged;
      always_comb begin
        for (int i = 0; i < 4; i++) begin
          merged[8*i +: 8] = strobes.laneMask[i] ? wrData[8*i +: 8]
                                                 : barVal[b][8*i +: 8];
        end
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          barVal[b] <= BAR_RESET;
        end else if (strobes.barHit[b]) begin
          barVal[b] <= strobes.barSize ? SIZED_VAL : {merged[31:2], IO_TYPE};
        end
      end
    end else begin : g_absent
      assign barVal[b] = 32'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intLine <= 8'h00;
    end else if (strobes.lineWe) begin
      intLine <= wrData[7:0];
    end
  end

  // Shadow byte array: constants plus stored fields
  logic [7:0] shadow [256];

  always_comb begin
    for (int k = 0; k < 256; k++) shadow[k] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      shadow[8'h00 + i] = ID_WORD[8*i +: 8];
      shadow[8'h2C + i] = ID_WORD[8*i +: 8];
      shadow[8'h10 + i] = barVal[0][8*i +: 8];
      shadow[8'h14 + i] = barVal[1][8*i +: 8];
    end
    shadow[8'h04] = CMD_RESET[7:0];
    shadow[8'h05] = CMD_RESET[15:8];
    shadow[8'h06] = STAT_RESET[7:0];
    shadow[8'h07] = STAT_RESET[15:8];
    shadow[8'h08] = REV_ID;
    shadow[8'h09] = PROG_IF;
    shadow[8'h0A] = SUB_CLASS;
    shadow[8'h0B] = BASE_CLASS;
    shadow[8'h34] = CAP_PTR;
    shadow[8'h3C] = intLine;
    shadow[8'h3D] = INT_PIN;
  end

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      logic [8:0] off;
      off = {1'b0, addr} + 9'(i);
      rdData[8*i +: 8] = (byteEn[i] && !off[8]) ? shadow[off[7:0]] : 8'h00;
    end
  end

endmodule

// File: rtl/serial_cfg_space.sv
module serial_cfg_space
  import serial_cfg_pkg::*;
#(
  parameter int          NUM_PORTS  = 2,
  parameter int          BAR_WINDOW = 8,
  parameter logic [31:0] ID_WORD    = 32'hC0DE_5A01
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  addr,
  input  logic [3:0]  byteEn,
  input  logic [31:0] wrData,
  input  logic        wrEn,
  output logic [31:0] rdData
);

  cfgStrobes_t strobes;

  serial_cfg_wr_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .dwIdx   (addr[7:2]),
    .byteEn  (byteEn),
    .wrData  (wrData),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  serial_cfg_dp #(
    .NUM_PORTS  (NUM_PORTS),
    .BAR_WINDOW (BAR_WINDOW),
    .ID_WORD    (ID_WORD)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (wrData),
    .addr    (addr),
    .byteEn  (byteEn),
    .rdData  (rdData)
  );

endmodule

// File: rtl/serial_cfg_space_chk.sv
module serial_cfg_space_chk #(
  parameter int          NUM_PORTS = 2,
  parameter logic [31:0] ID_WORD   = 32'hC0DE_5A01
) (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  addr,
  input logic [3:0]  byteEn,
  input logic [31:0] wrData,
  input logic        wrEn,
  input logic [31:0] rdData
);

  logic fullRead;
  assign fullRead = (byteEn == 4'hF);

  // R1
  cmd_status_chk: assert property (@(posedge clk) disable iff (rst)
    (fullRead && addr == 8'h04) |-> (rdData == 32'h0200_0001));

  // R4
  bar0_size_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr[7:2] == 6'h04 && fullRead && wrData == 32'hFFFF_FFFF)
    |=> (!(addr == 8'h10 && byteEn == 4'hF) || rdData == 32'hFFFF_FFF9));

  // R5
  bar0_type_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == 8'h10 && byteEn[0]) |-> (rdData[1:0] == 2'b01));

  // R8
  unused_bar_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == 8'h18 || addr == 8'h1C || addr == 8'h20) |-> (rdData == 32'd0));

  // R9
  int_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == 8'h3C && byteEn[1]) |-> (rdData[15:8] == 8'h01));

  // R10
  subsys_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (fullRead && addr == 8'h2C) |-> (rdData == ID_WORD));

  if (NUM_PORTS == 1) begin : g_single
    // R7
    bar1_absent_chk: assert property (@(posedge clk) disable iff (rst)
      (addr == 8'h14) |-> (rdData == 32'd0));
  end

endmodule

bind serial_cfg_space serial_cfg_space_chk #(
  .NUM_PORTS (NUM_PORTS),
  .ID_WORD   (ID_WORD)
) u_chk (.*);

// File: tb/serial_cfg_space_tb.sv
module serial_cfg_space_tb;

  localparam logic [31:0] ID = 32'hC0DE_5A01;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h00;
  logic [3:0]  byteEn = 4'h0;
  logic [31:0] wrData = 32'd0;
  logic        wrEn = 1'b0;
  logic [31:0] rdDual, rdSingle;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_cfg_space #(.NUM_PORTS(2), .ID_WORD(ID)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .byteEn(byteEn),
    .wrData(wrData), .wrEn(wrEn), .rdData(rdDual));

  serial_cfg_space #(.NUM_PORTS(1), .ID_WORD(ID)) u_dut_single (
    .clk(clk), .rst(rst), .addr(addr), .byteEn(byteEn),
    .wrData(wrData), .wrEn(wrEn), .rdData(rdSingle));

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be,
                    input logic [31:0] d);
    @(negedge clk);
    addr = a; byteEn = be; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; byteEn = 4'h0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] be,
                    output logic [31:0] dual, output logic [31:0] single);
    @(negedge clk);
    addr = a; byteEn = be; wrEn = 1'b0;
    #2;
    dual = rdDual;
    single = rdSingle;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d, s;
    rd(8'h04, 4'hF, d, s); check("R1 cmd/status", d, 32'h0200_0001);
    rd(8'h08, 4'hF, d, s); check("R2 class/rev", d, 32'h0700_0210);
    rd(8'h10, 4'hF, d, s); check("R3 bar0 reset", d, 32'h0000_0001);
    rd(8'h14, 4'hF, d, s); check("R3 bar1 reset dual", d, 32'h0000_0001);
    check("R7 bar1 absent single", s, 32'd0);
    rd(8'h00, 4'hF, d, s); check("R10 id word", d, ID);
    rd(8'h2C, 4'hF, d, s); check("R10 subsys mirror", d, ID);
    rd(8'h34, 4'hF, d, s); check("R9 cap ptr", d, 32'd0);
    rd(8'h3C, 4'hF, d, s); check("R9 intr reset", d, 32'h0000_0100);
  endtask

  task automatic t_readonly();
    logic [31:0] d, s;
    wr(8'h04, 4'hF, 32'h0000_0000);
    rd(8'h04, 4'hF, d, s); check("R1 cmd write ignored", d, 32'h0200_0001);
    wr(8'h18, 4'hF, 32'h1234_5678);
    wr(8'h1C, 4'hF, 32'hFFFF_FFFF);
    wr(8'h20, 4'hF, 32'hAAAA_5555);
    rd(8'h18, 4'hF, d, s); check("R8 bar2 zero", d, 32'd0);
    rd(8'h1C, 4'hF, d, s); check("R8 bar3 zero", d, 32'd0);
    rd(8'h20, 4'hF, d, s); check("R8 bar4 zero", d, 32'd0);
    wr(8'h40, 4'hF, 32'hDEAD_BEEF);
    rd(8'h40, 4'hF, d, s); check("R12 unlisted ignored", d, 32'd0);
    wr(8'h3C, 4'hF, 32'hFFFF_FF5A);
    rd(8'h3C, 4'hF, d, s); check("R9 intr line written, pin fixed", d, 32'h0000_015A);
  endtask

  task automatic t_sizing();
    logic [31:0] d, s;
    wr(8'h10, 4'hF, 32'hFFFF_FFFF);
    wr(8'h14, 4'hF, 32'hFFFF_FFFF);
    rd(8'h10, 4'hF, d, s);
    check("R4 bar0 size dual", d, 32'hFFFF_FFF9);
    check("R4 bar0 size single", s, 32'hFFFF_FFF9);
    rd(8'h14, 4'hF, d, s);
    check("R4 bar1 size dual", d, 32'hFFFF_FFF9);
    check("R7 bar1 write discarded single", s, 32'd0);
  endtask

  task automatic t_bar_values();
    logic [31:0] d, s;
    wr(8'h10, 4'hF, 32'h0000_C0F2);
    rd(8'h10, 4'hF, d, s); check("R5 bar0 plain value", d, 32'h0000_C0F1);
    wr(8'h10, 4'b0010, 32'h0000_AB00);
    rd(8'h10, 4'hF, d, s); check("R6 bar0 lane1 only", d, 32'h0000_ABF1);
    wr(8'h10, 4'b0001, 32'h0000_00FF);
    rd(8'h10, 4'hF, d, s); check("R6 bar0 lane0 low bits kept", d, 32'h0000_ABFD);
    wr(8'h10, 4'b0111, 32'hFFFF_FFFF);
    rd(8'h10, 4'hF, d, s); check("R6 partial all-ones no sizing", d, 32'h00FF_FFFD);
    // wrEn low: no effect
    @(negedge clk);
    addr = 8'h10; byteEn = 4'hF; wrData = 32'h1111_1110; wrEn = 1'b0;
    @(negedge clk);
    rd(8'h10, 4'hF, d, s); check("R12 no write without strobe", d, 32'h00FF_FFFD);
  endtask

  task automatic t_unaligned();
    logic [31:0] d, s;
    wr(8'h12, 4'hF, 32'h1122_3344);
    rd(8'h10, 4'hF, d, s); check("R12 write to aligned dword", d, 32'h1122_3345);
    rd(8'h11, 4'b0011, d, s); check("R11 unaligned word read", d, 32'h0000_2233);
    rd(8'h06, 4'b0011, d, s); check("R11 status word read", d, 32'h0000_0200);
    rd(8'h0B, 4'hF, d, s); check("R11 dword read across fields", d, 32'h0000_0007);
    rd(8'h3D, 4'b0001, d, s); check("R11 single byte read", d, 32'h0000_0001);
    rd(8'h3C, 4'b0010, d, s); check("R11 disabled lane zero", d, 32'h0000_0100);
    rd(8'hFD, 4'hF, d, s); check("R11 past end zero", d, 32'd0);
  endtask

  task automatic t_sync_reset();
    logic [31:0] d, s;
    wr(8'h14, 4'hF, 32'h0000_8000);
    do_reset();
    rd(8'h10, 4'hF, d, s); check("R13 bar0 restored", d, 32'h0000_0001);
    rd(8'h14, 4'hF, d, s); check("R13 bar1 restored", d, 32'h0000_0001);
    rd(8'h3C, 4'h1, d, s); check("R13 intr line restored", d, 32'h0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_readonly();
    t_sizing();
    t_bar_values();
    t_unaligned();
    t_sync_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule